// File: doc/BRIEF.md
# Reflected CRC-8 Byte Accumulator

This block keeps a running 8-bit checksum of the kind used to protect identity codes and data on a single-wire device bus. The checksum polynomial is x^8+x^5+x^4+1, applied in reflected form: the constant 0x8C is folded in, bits are taken least significant first, the register starts at zero and the output gets no final inversion. A client clears the accumulator at the start of a message, then presents bytes one at a time with a valid strobe. The value on the output after each byte matches what a 256-entry lookup table would give for the index `crc ^ byte`.

A parameter selects one of two builds. The unrolled build takes a byte on every cycle and folds all eight bits within a single cycle. The serial build folds one bit per cycle over eight cycles and drops its ready output while it works. A zero flag lets a receiver check a message directly: when the message is followed by its own checksum byte, the register ends at zero.

Top module: `crc8_accum`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `crcOut` is 0x00, `crcZero` is 1 and `ready` is 1.
- R2: A cycle with `clearIn` high sets `crcOut` to 0x00 at the next rising edge, whatever value it held before.
- R3: When `clearIn` and `byteValid` are high in the same cycle, the byte is dropped and `crcOut` becomes 0x00.
- R4: An accepted byte b moves the register from c to T[c ^ b]. T[x] is computed by eight steps, least significant bit first. Each step shifts x right by one and, if the bit shifted out was 1, XORs the result with 0x8C. This gives T[0]=0x00, T[1]=0x5E, T[128]=0x8C and T[255]=0x35.
- R5: No final XOR or inversion is applied: `crcOut` is the register value itself, so a single byte 0x01 from a cleared state reads back as 0x5E.
- R6: `crcZero` is 1 exactly when `crcOut` is 0x00. A message followed by its own final checksum byte leaves `crcZero` at 1.
- R7: In the unrolled build (SERIAL=0), `ready` stays high after reset. A byte accepted at one edge is reflected in `crcOut` right after that edge, so bytes may arrive on consecutive cycles.
- R8: In the serial build (SERIAL=1), `ready` goes low at the edge that accepts a byte and comes back high eight edges later. The updated `crcOut` is valid from that point on.
- R9: In the serial build, `byteValid` while `ready` is low has no effect on the final checksum.
- R10: In the serial build, `clearIn` while a byte is still being folded aborts that byte. At the next edge, `crcOut` is 0x00 and `ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| clearIn | input | 1 | Restart the checksum at zero; has priority over a byte |
| byteValid | input | 1 | `byteIn` holds a byte to fold in; taken when `ready` is high |
| byteIn | input | 8 | Data byte |
| ready | output | 1 | Block can take a byte this cycle |
| crcOut | output | 8 | Running checksum |
| crcZero | output | 1 | High when `crcOut` is zero |

## Verification
The assertions assume that `clearIn` and `byteValid` are clean synchronous strobes. They also assume that no byte is counted as accepted unless `ready` was high in that cycle. The bench drives every input at the falling edge so each strobe is settled for a whole cycle. The one test that deliberately raises `byteValid` while the serial build is busy drops that strobe at the first falling edge where `ready` is seen high again, so no unintended byte is taken. Expected checksums come from a bitwise reference computed in the bench. The bench sweeps all 256 single bytes on both builds and runs random multi-byte messages, each closed by its own checksum byte.

// File: rtl/crc8_accum_pkg.sv
package crc8_accum_pkg;

  // Strobes issued by the control unit to the datapath each cycle.
  typedef struct packed {
    logic clear;  // zero the register
    logic load;   // a byte is taken this cycle
    logic step;   // fold one bit (serial build only)
  } crcStrobes_t;

  // One reflected bit step: shift right, fold polynomial when the
  // outgoing bit differs from the data bit.
  function automatic logic [7:0] foldBit(input logic [7:0] cur,
                                         input logic       bitIn,
                                         input logic [7:0] poly);
    logic [7:0] shifted;
    shifted = cur >> 1;
    return (cur[0] ^ bitIn) ? (shifted ^ poly) : shifted;
  endfunction

endpackage

// File: rtl/crc8_accum_ctrl.sv
module crc8_accum_ctrl
  import crc8_accum_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter bit SERIAL = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        clearIn,
  input  logic        byteValid,
  output logic        ready,
  output crcStrobes_t strobes
);

  localparam int CNT_W = $clog2(BYTE_W + 1);

  generate
    if (SERIAL) begin : gSerial
      logic [CNT_W-1:0] bitsLeft;
      logic             idle;

      assign idle          = (bitsLeft == '0);
      assign ready         = idle;
      assign strobes.clear = clearIn;
      assign strobes.load  = byteValid && idle && !clearIn;
      assign strobes.step  = !idle && !clearIn;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          bitsLeft <= '0;
        end else if (clearIn) begin
          bitsLeft <= '0;
        end else if (byteValid && idle) begin
          bitsLeft <= CNT_W'(BYTE_W);
        end else if (!idle) begin
          bitsLeft <= bitsLeft - 1'b1;
        end
      end

      // A taken byte makes the unit busy on the next cycle.
      assert_busy_after_take_R8: assert property (@(posedge clk) disable iff (!rstN)
        (byteValid && ready && !clearIn) |=> !ready);

      // Ready only returns after a bit step or an abort.
      assert_ready_returns_R8: assert property (@(posedge clk) disable iff (!rstN)
        $rose(ready) |-> ($past(strobes.step) || $past(clearIn)));
    end else begin : gUnrolled
      assign ready         = 1'b1;
      assign strobes.clear = clearIn;
      assign strobes.load  = byteValid && !clearIn;
      assign strobes.step  = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/crc8_accum_dp.sv
module crc8_accum_dp
  import crc8_accum_pkg::*;
#(
  parameter int         BYTE_W = 8,
  parameter logic [7:0] POLY   = 8'h8C,
  parameter bit         SERIAL = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  crcStrobes_t       strobes,
  input  logic [BYTE_W-1:0] byteIn,
  output logic [7:0]        crcOut,
  output logic              crcZero
);

  logic [7:0] crcReg;

  generate
    if (SERIAL) begin : gSerial
      logic [BYTE_W-1:0] dataSh;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          crcReg <= '0;
          dataSh <= '0;
        end else if (strobes.clear) begin
          crcReg <= '0;
          dataSh <= '0;
        end else if (strobes.load) begin
          dataSh <= byteIn;
        end else if (strobes.step) begin
          crcReg <= foldBit(crcReg, dataSh[0], POLY);
          dataSh <= dataSh >> 1;
        end
      end
    end else begin : gUnrolled
      logic [7:0] nextCrc;

      always_comb begin
        nextCrc = crcReg;
        for (int i = 0; i < BYTE_W; i++) begin
          nextCrc = foldBit(nextCrc, byteIn[i], POLY);
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          crcReg <= '0;
        end else if (strobes.clear) begin
          crcReg <= '0;
        end else if (strobes.load) begin
          crcReg <= nextCrc;
        end
      end
    end
  endgenerate

  assign crcOut  = crcReg;
  assign crcZero = (crcReg == 8'h00);

  // A clear strobe from control leaves the register at zero.
  assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (crcOut == 8'h00));

  // Without any strobe the register holds its value.
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.clear && !strobes.load && !strobes.step) |=> $stable(crcOut));

endmodule

// File: rtl/crc8_accum.sv
module crc8_accum
  import crc8_accum_pkg::*;
#(
  parameter logic [7:0] POLY   = 8'h8C,
  parameter bit         SERIAL = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clearIn,
  input  logic       byteValid,
  input  logic [7:0] byteIn,
  output logic       ready,
  output logic [7:0] crcOut,
  output logic       crcZero
);

  localparam int BYTE_W = 8;

  crcStrobes_t strobes;

  crc8_accum_ctrl #(
    .BYTE_W (BYTE_W),
    .SERIAL (SERIAL)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .clearIn   (clearIn),
    .byteValid (byteValid),
    .ready     (ready),
    .strobes   (strobes)
  );

  crc8_accum_dp #(
    .BYTE_W (BYTE_W),
    .POLY   (POLY),
    .SERIAL (SERIAL)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .byteIn  (byteIn),
    .crcOut  (crcOut),
    .crcZero (crcZero)
  );

  // Clear wins over a byte in the same cycle: zero and idle next.
  assert_clear_priority_R3: assert property (@(posedge clk) disable iff (!rstN)
    clearIn |=> (crcOut == 8'h00 && ready && crcZero));

endmodule

// File: tb/crc8_accum_bench.sv
module crc8_accum_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic       clr [2];
  logic       val [2];
  logic [7:0] dat [2];
  logic       rdy [2];
  logic [7:0] crc [2];
  logic       zro [2];
  logic [7:0] model [2];

  int checks = 0;
  int errors = 0;

  crc8_accum #(.SERIAL(1'b0)) u_crc8_accum (
    .clk(clk), .rstN(rstN), .clearIn(clr[0]), .byteValid(val[0]),
    .byteIn(dat[0]), .ready(rdy[0]), .crcOut(crc[0]), .crcZero(zro[0]));

  crc8_accum #(.SERIAL(1'b1)) u_crc8_accum_serial (
    .clk(clk), .rstN(rstN), .clearIn(clr[1]), .byteValid(val[1]),
    .byteIn(dat[1]), .ready(rdy[1]), .crcOut(crc[1]), .crcZero(zro[1]));

  function automatic logic [7:0] tbl(input logic [7:0] idx);
    logic [7:0] x = idx;
    for (int k = 0; k < 8; k++) x = x[0] ? ((x >> 1) ^ 8'h8C) : (x >> 1);
    return x;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearAcc(input int m);
    @(negedge clk); clr[m] = 1'b1;
    @(negedge clk); clr[m] = 1'b0;
    model[m] = 8'h00;
  endtask

  task automatic sendByte(input int m, input logic [7:0] b, input string req);
    int n;
    @(negedge clk); val[m] = 1'b1; dat[m] = b;
    @(negedge clk); val[m] = 1'b0;
    model[m] = tbl(model[m] ^ b);
    if (m == 1) begin
      n = 0;
      while (!rdy[1] && n < 20) begin @(negedge clk); n++; end
      check("R8 serial latency", n, 8);
    end
    check(req, crc[m], model[m]);
    check("R6 zero flag", zro[m], (model[m] == 8'h00));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      clr[m] = 0; val[m] = 0; dat[m] = 0; model[m] = 0;
    end
    repeat (3) @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      check("R1 reset crc", crc[m], 0);
      check("R1 reset zero", zro[m], 1);
      check("R1 reset ready", rdy[m], 1);
    end
    rstN = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      check("R1 post-reset crc", crc[m], 0);
      check("R1 post-reset ready", rdy[m], 1);
    end

    for (int m = 0; m < 2; m++) begin
      // R4/R5: stated table points, literal values
      clearAcc(m); sendByte(m, 8'h01, "R4 byte");
      check("R5 T[1]", crc[m], 8'h5E);
      clearAcc(m); sendByte(m, 8'h80, "R4 byte");
      check("R4 T[128]", crc[m], 8'h8C);
      clearAcc(m); sendByte(m, 8'hFF, "R4 byte");
      check("R4 T[255]", crc[m], 8'h35);
      clearAcc(m); sendByte(m, 8'h00, "R4 byte");
      check("R4 T[0]", crc[m], 8'h00);

      // R4: exhaustive single-byte sweep
      for (int i = 0; i < 256; i++) begin
        clearAcc(m);
        check("R2 clear", crc[m], 0);
        sendByte(m, 8'(i), "R4 sweep");
      end

      // R6: random messages closed by their checksum
      for (int msg = 0; msg < 20; msg++) begin
        int len = 1 + ($urandom % 12);
        clearAcc(m);
        for (int j = 0; j < len; j++) sendByte(m, 8'($urandom), "R4 random");
        sendByte(m, crc[m], "R4 closing byte");
        check("R6 message residue zero", zro[m], 1);
      end

      // R3: clear and byte together
      clearAcc(m); sendByte(m, 8'hA7, "R4 byte");
      @(negedge clk); clr[m] = 1'b1; val[m] = 1'b1; dat[m] = 8'h55;
      @(negedge clk); clr[m] = 1'b0; val[m] = 1'b0;
      check("R3 clear priority crc", crc[m], 0);
      check("R3 clear priority ready", rdy[m], 1);
      model[m] = 8'h00;
    end

    // R7: unrolled build, back-to-back bytes
    clearAcc(0);
    @(negedge clk); val[0] = 1'b1;
    for (int j = 0; j < 4; j++) begin
      dat[0] = 8'(8'h31 + j);
      @(negedge clk);
      model[0] = tbl(model[0] ^ 8'(8'h31 + j));
      check("R7 back-to-back crc", crc[0], model[0]);
      check("R7 ready held", rdy[0], 1);
    end
    val[0] = 1'b0;

    // R9: byteValid while busy is ignored
    clearAcc(1);
    @(negedge clk); val[1] = 1'b1; dat[1] = 8'h3C;
    @(negedge clk); dat[1] = 8'hE1;
    check("R8 busy after take", rdy[1], 0);
    while (!rdy[1]) @(negedge clk);
    val[1] = 1'b0;
    @(negedge clk);
    check("R9 busy byte ignored", crc[1], tbl(8'h3C));

    // R10: clear aborts a byte in progress
    clearAcc(1); sendByte(1, 8'h5A, "R4 byte");
    @(negedge clk); val[1] = 1'b1; dat[1] = 8'h99;
    @(negedge clk); val[1] = 1'b0;
    repeat (3) @(negedge clk);
    clr[1] = 1'b1;
    @(negedge clk); clr[1] = 1'b0;
    check("R10 abort crc", crc[1], 0);
    check("R10 abort ready", rdy[1], 1);
    repeat (10) @(negedge clk);
    check("R10 abort stays zero", crc[1], 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule